// File: doc/BRIEF.md
# Over-Current Alarm Throttle Controller

This block watches an over-current alarm input from outside the chip and makes two decisions: when to request throttling and when to raise an interrupt. The raw alarm first passes through a synchroniser. It is then normalised to an active-high level according to a programmable polarity. Each time the normalised alarm goes from inactive to active, the block counts one event.

The event count is cleared only when a quiet window expires. The window length is programmable in clock cycles, and the window restarts on every new event. The interrupt is sticky and is raised when the count passes a programmable threshold. After the alarm goes away, the throttle request is held for a programmable number of microseconds. A prescaler, set by a parameter giving the clocks per microsecond, produces the microsecond tick.

Software configures the block through a simple write-only register port. It reads the event count and the interrupt flag directly as outputs.

Top module: `oc_throttle_ctrl`

## Requirements
- R1: After reset, `throttle_o`, `irq_o` and `evt_count_o` are 0. The register reset values are: polarity active-high, interrupt disabled, threshold 0, filter 0, hold 0.
- R2: The alarm passes through `SYNC_STAGES` flops (2 by default) and one further state flop. A change on `alarm_i` that is set up before clock edge 1 first shows on `throttle_o` after edge 3.
- R3: Register address 0, bit 0, selects the polarity: 1 means active-low and 0 means active-high. The normalised alarm is the synchronised input XOR this bit.
- R4: Each inactive-to-active transition of the normalised alarm adds 1 to `evt_count_o`. The count saturates at 2^CNT_W-1.
- R5: Register address 0, bit 1, enables interrupts. Address 1 holds the threshold. When interrupts are enabled, an event sets `irq_o` on the next edge if the count after that event is greater than the threshold. A threshold of 0 therefore interrupts on every event.
- R6: While the interrupt enable bit is 0, `irq_o` never sets, whatever the count.
- R7: `irq_o` is sticky. Writing a 1 to bit 0 of address 4 clears it. If a clear and a trigger fall in the same cycle, the flag stays set.
- R8: Address 2 holds the filter length F. When F>0, the count is cleared after F consecutive clock cycles with no event, and the window then restarts. When F=0, the count is never cleared.
- R9: Address 3 holds the hold time H in microseconds. `throttle_o` is high while the registered alarm is active. After the alarm deasserts, it stays high for exactly H*CLKS_PER_US further cycles. H=0 gives no extension.
- R10: An alarm that arrives during a hold period keeps the throttle high. The full hold time is reloaded when that alarm deasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 1 | Raw over-current alarm, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| throttle_o | output | 1 | Throttle request level |
| irq_o | output | 1 | Sticky interrupt flag |
| evt_count_o | output | CNT_W | Current event count |

## Verification
The bench builds the block with a 4-bit counter so that saturation is reached after 15 events. CLKS_PER_US is set to 4, which makes hold periods of a few microseconds last only tens of cycles. The filter register is 8 bits wide, so windows of 10 to 20 cycles can expire within a short run. With these values, the count clear, the hold reload and the clear-versus-trigger collision all occur within a few hundred cycles, and they are compared against the cycle model on every clock.

// File: rtl/oc_thr_pkg.sv
package oc_thr_pkg;
   localparam int ADDR_CTRL   = 0;
   localparam int ADDR_THRESH = 1;
   localparam int ADDR_FILTER = 2;
   localparam int ADDR_HOLD   = 3;
   localparam int ADDR_IRQCLR = 4;

   localparam int CTRL_POL_BIT = 0;
   localparam int CTRL_IEN_BIT = 1;
   localparam int CLR_BIT      = 0;

   typedef struct packed {
      logic pol_low;
      logic irq_en;
   } oc_ctrl_t;
endpackage

// File: rtl/oc_thr_regs.sv
module oc_thr_regs
   import oc_thr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 8,
   parameter int FILT_W = 24,
   parameter int HOLD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output oc_ctrl_t          ctrl,
   output logic [CNT_W-1:0]  thresh,
   output logic [FILT_W-1:0] filt_len,
   output logic [HOLD_W-1:0] hold_us,
   output logic              irq_clr
);
   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         thresh   <= '0;
         filt_len <= '0;
         hold_us  <= '0;
      end else if (wr_en) begin
         case (int'(wr_addr))
            ADDR_CTRL: begin
               ctrl.pol_low <= wr_data[CTRL_POL_BIT];
               ctrl.irq_en  <= wr_data[CTRL_IEN_BIT];
            end
            ADDR_THRESH: thresh   <= wr_data[CNT_W-1:0];
            ADDR_FILTER: filt_len <= wr_data[FILT_W-1:0];
            ADDR_HOLD:   hold_us  <= wr_data[HOLD_W-1:0];
            default: ;
         endcase
      end
   end

   assign irq_clr = wr_en && (int'(wr_addr) == ADDR_IRQCLR) && wr_data[CLR_BIT];
endmodule

// File: rtl/oc_alarm_front.sv
module oc_alarm_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_raw,
   input  logic pol_low,
   output logic act_q,
   output logic rise,
   output logic fall
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], alarm_raw};
   end

   assign act = sync_q[SYNC_STAGES-1] ^ pol_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign rise = act & ~act_q;
   assign fall = ~act & act_q;

   // R2: the registered level follows the normalised level one edge later
   p_act_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> act_q);
   p_fall_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !act_q);
endmodule

// File: rtl/oc_event_track.sv
module oc_event_track #(
   parameter int CNT_W  = 8,
   parameter int FILT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              irq_en,
   input  logic [CNT_W-1:0]  thresh,
   input  logic [FILT_W-1:0] filt_len,
   input  logic              irq_clr,
   output logic [CNT_W-1:0]  count,
   output logic              irq_flag
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [FILT_W-1:0] quiet_q;
   logic              expire;
   logic [CNT_W-1:0]  count_nx;
   logic              trig;

   assign expire = (filt_len != '0) && !rise && (quiet_q >= filt_len - 1'b1);

   always_comb begin
      if (rise)        count_nx = (count == CNT_MAX) ? CNT_MAX : count + 1'b1;
      else if (expire) count_nx = '0;
      else             count_nx = count;
   end

   assign trig = rise && irq_en && (count_nx > thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q  <= '0;
         count    <= '0;
         irq_flag <= 1'b0;
      end else begin
         quiet_q  <= (rise || expire || filt_len == '0) ? '0 : quiet_q + 1'b1;
         count    <= count_nx;
         irq_flag <= trig | (irq_flag & ~irq_clr);
      end
   end

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && count != CNT_MAX) |=> count == $past(count) + 1'b1);
   p_count_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && count == CNT_MAX) |=> count == CNT_MAX);
   p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !irq_flag) |=> !irq_flag);
   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);
   p_filt_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_len == '0 && !rise) |=> $stable(count));
endmodule

// File: rtl/oc_hold_timer.sv
module oc_hold_timer #(
   parameter int HOLD_W      = 16,
   parameter int CLKS_PER_US = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic [HOLD_W-1:0] hold_us,
   output logic              busy
);
   logic              tick;
   logic [HOLD_W-1:0] hold_q;

   generate
      if (CLKS_PER_US == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(CLKS_PER_US);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
         logic [PRE_W-1:0] pre_q;
         assign tick = (pre_q == PRE_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (fall)  pre_q <= '0;
            else if (tick)  pre_q <= '0;
            else            pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    hold_q <= '0;
      else if (fall)                 hold_q <= hold_us;
      else if (tick && hold_q != '0) hold_q <= hold_q - 1'b1;
   end

   assign busy = (hold_q != '0);

   p_hold_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> hold_q == $past(hold_us));
   p_hold_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && hold_q != '0) |=> hold_q <= $past(hold_q));
endmodule

// File: rtl/oc_throttle_ctrl.sv
module oc_throttle_ctrl
   import oc_thr_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int CNT_W       = 8,
   parameter int FILT_W      = 24,
   parameter int HOLD_W      = 16,
   parameter int CLKS_PER_US = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alarm_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              throttle_o,
   output logic              irq_o,
   output logic [CNT_W-1:0]  evt_count_o
);
   generate
      if (DATA_W < CNT_W || DATA_W < FILT_W || DATA_W < HOLD_W || DATA_W < 2) begin : g_bad_data
         $error("DATA_W too narrow for the configured fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (CNT_W < 2 || FILT_W < 1 || HOLD_W < 1) begin : g_bad_width
         $error("field widths out of range");
      end
      if (CLKS_PER_US < 1) begin : g_bad_pre
         $error("CLKS_PER_US must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   oc_ctrl_t          ctrl;
   logic [CNT_W-1:0]  thresh;
   logic [FILT_W-1:0] filt_len;
   logic [HOLD_W-1:0] hold_us;
   logic              irq_clr;
   logic              act_q, rise, fall, hold_busy;

   oc_thr_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl(ctrl), .thresh(thresh), .filt_len(filt_len), .hold_us(hold_us), .irq_clr(irq_clr)
   );

   oc_alarm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .alarm_raw(alarm_i), .pol_low(ctrl.pol_low),
      .act_q(act_q), .rise(rise), .fall(fall)
   );

   oc_event_track #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .rise(rise), .irq_en(ctrl.irq_en), .thresh(thresh),
      .filt_len(filt_len), .irq_clr(irq_clr), .count(evt_count_o), .irq_flag(irq_o)
   );

   oc_hold_timer #(.HOLD_W(HOLD_W), .CLKS_PER_US(CLKS_PER_US)) u_hold (
      .clk(clk), .rst_n(rst_n), .fall(fall), .hold_us(hold_us), .busy(hold_busy)
   );

   assign throttle_o = act_q | hold_busy;

   // R9: a deasserting alarm never drops the throttle on the next edge while hold is set
   p_hold_bridge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && hold_us != '0) |=> throttle_o);
   // R7: a write-one-to-clear with no new event empties the flag
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !rise) |=> !irq_o);
endmodule

// File: tb/sim_oc_throttle_ctrl.sv
module sim_oc_throttle_ctrl;
   localparam int DATA_W = 16, ADDR_W = 3, CNT_W = 4, FILT_W = 8, HOLD_W = 6;
   localparam int CPU = 4;
   localparam int MAXC = (1 << CNT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, alarm_i = 1'b0, wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic throttle_o, irq_o;
   logic [CNT_W-1:0] evt_count_o;

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit done = 0;

   always #5 clk = ~clk;

   oc_throttle_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FILT_W(FILT_W),
      .HOLD_W(HOLD_W), .CLKS_PER_US(CPU), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .throttle_o(throttle_o), .irq_o(irq_o), .evt_count_o(evt_count_o));

   // behavioural reference model
   int m_s1, m_s2, m_prev, m_cnt, m_quiet, m_flag, m_pre, m_hold;
   int m_pol, m_ien, m_thr, m_filt, m_holdset;

   always @(posedge clk) begin
      int norm, rise, fall, expire, cnt_n, trig, clr, tick;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_quiet = 0; m_flag = 0;
         m_pre = 0; m_hold = 0; m_pol = 0; m_ien = 0; m_thr = 0; m_filt = 0; m_holdset = 0;
      end else begin
         norm = m_s2 ^ m_pol;
         rise = (norm && !m_prev) ? 1 : 0;
         fall = (!norm && m_prev) ? 1 : 0;
         expire = (m_filt != 0 && !rise && m_quiet >= m_filt - 1) ? 1 : 0;
         if (rise) cnt_n = (m_cnt == MAXC) ? MAXC : m_cnt + 1;
         else if (expire) cnt_n = 0;
         else cnt_n = m_cnt;
         trig = (rise && m_ien && cnt_n > m_thr) ? 1 : 0;
         clr = (wr_en && wr_addr == 3'd4 && wr_data[0]) ? 1 : 0;
         m_flag = (trig || (m_flag && !clr)) ? 1 : 0;
         m_quiet = (rise || expire || m_filt == 0) ? 0 : m_quiet + 1;
         if (fall) begin
            m_hold = m_holdset; m_pre = 0;
         end else begin
            tick = (m_pre == CPU - 1) ? 1 : 0;
            if (tick && m_hold != 0) m_hold = m_hold - 1;
            m_pre = tick ? 0 : m_pre + 1;
         end
         m_cnt = cnt_n; m_prev = norm; m_s2 = m_s1; m_s1 = alarm_i;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_pol = wr_data[0]; m_ien = wr_data[1]; end
               3'd1: m_thr = wr_data[CNT_W-1:0];
               3'd2: m_filt = wr_data[FILT_W-1:0];
               3'd3: m_holdset = wr_data[HOLD_W-1:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "throttle", throttle_o, (m_prev || m_hold != 0) ? 1 : 0);
         check(cur_req, "irq", irq_o, m_flag);
         check(cur_req, "count", evt_count_o, m_cnt);
      end
   end

   task automatic wr(int addr, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(bit lvl, int len, int gap);
      @(negedge clk);
      alarm_i = lvl;
      repeat (len) @(negedge clk);
      alarm_i = ~lvl;
      repeat (gap) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      cur_req = "R1";
      check("R1", "throttle", throttle_o, 0);
      check("R1", "irq", irq_o, 0);
      check("R1", "count", evt_count_o, 0);

      // R2 latency: visible after the third edge
      cur_req = "R2";
      alarm_i = 1'b1;
      idle(2);
      check("R2", "throttle before 3rd edge", throttle_o, 0);
      idle(1);
      check("R2", "throttle after 3rd edge", throttle_o, 1);
      alarm_i = 1'b0;
      idle(6);

      // R6 counting with interrupts disabled
      cur_req = "R6";
      for (int i = 0; i < 5; i++) pulse(1'b1, 2, 3);
      idle(3);
      check("R6", "irq disabled", irq_o, 0);
      check("R4", "count after 6 events", evt_count_o, 6);

      // R8 filter off keeps count, filter on clears it
      cur_req = "R8";
      idle(40);
      check("R8", "filter 0 keeps count", evt_count_o, 6);
      wr(2, 20);
      idle(30);
      check("R8", "filter expiry clears count", evt_count_o, 0);
      for (int i = 0; i < 3; i++) pulse(1'b1, 2, 3);
      idle(3);
      check("R8", "events within window", evt_count_o, 3);
      wr(2, 0);

      // R5 threshold
      cur_req = "R5";
      wr(1, 3);
      wr(0, 2);
      idle(2);
      check("R5", "no irq without new event", irq_o, 0);
      pulse(1'b1, 2, 4);
      check("R5", "irq when count exceeds threshold", irq_o, 1);

      // R7 clear and collision
      cur_req = "R7";
      wr(4, 1);
      idle(1);
      check("R7", "cleared", irq_o, 0);
      wr(1, 0);
      @(negedge clk);
      alarm_i = 1'b1;
      idle(2);
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7", "trigger wins over clear", irq_o, 1);
      alarm_i = 1'b0;
      idle(4);
      wr(4, 1);
      idle(1);
      check("R5", "cleared before saturation run", irq_o, 0);

      // R4 saturation
      cur_req = "R4";
      wr(1, MAXC);
      for (int i = 0; i < 20; i++) pulse(1'b1, 2, 2);
      idle(3);
      check("R4", "count saturates", evt_count_o, MAXC);
      check("R5", "no irq above max threshold", irq_o, 0);

      // R3 active-low polarity
      cur_req = "R3";
      alarm_i = 1'b1;
      idle(4);
      wr(0, 1);
      idle(4);
      wr(2, 10);
      idle(15);
      wr(2, 0);
      check("R3", "count cleared before polarity test", evt_count_o, 0);
      for (int i = 0; i < 2; i++) pulse(1'b0, 2, 3);
      idle(3);
      check("R3", "active-low events counted", evt_count_o, 2);
      check("R3", "idle high is inactive", throttle_o, 0);

      // R9 hold time
      cur_req = "R9";
      wr(3, 3);
      pulse(1'b0, 3, 8);
      check("R9", "held after deassert", throttle_o, 1);
      idle(3 * CPU + 2);
      check("R9", "released after hold", throttle_o, 0);

      // R10 reload during hold
      cur_req = "R10";
      pulse(1'b0, 3, 10);
      pulse(1'b0, 2, 14);
      check("R10", "still held after reload", throttle_o, 1);
      idle(3 * CPU);
      check("R10", "released after reloaded hold", throttle_o, 0);

      // R9 zero hold
      cur_req = "R9";
      wr(3, 0);
      pulse(1'b0, 3, 4);
      check("R9", "zero hold releases promptly", throttle_o, 0);
      idle(4);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule